// File: doc/BRIEF.md
# UART Receive Byte Buffer with Status

This block sits between a UART deserialiser and a register bus. The deserialiser offers one byte per cycle on a push port, and a bus read strobe removes the oldest byte. Software selects one of two storage modes through a small control word. In queue mode, bytes are kept in a first-in first-out store of parameterised depth. In single-register mode, each new byte overwrites one holding register. A status word reports how many bytes are stored, with a dedicated full flag. A data-ready bit tells software that a byte is waiting.

Line events are collected in a sticky error-status word that clears when it is read. The deserialiser supplies these events: overrun, parity and framing errors, and a line break. A break also stores a 0x00 byte. Two single-cycle request pulses feed an interrupt controller. One marks every stored byte. The other marks errors: a dropped byte, a read from an empty queue, a break or a line error. A control write can flush the receive queue. It can also issue a one-cycle flush pulse to the transmit side. Both flush bits clear themselves.

Top module: `uart_rx_stash`

## Requirements
- R1: After reset, the status word is 0, data-ready is low, the error status is 0, the control readback is 0 (single-register mode), and both request pulses and the flush pulse are low.
- R2: In queue mode, bytes are read back in arrival order, and status bits 7:0 give the number of stored bytes.
- R3: When the queue holds DEPTH bytes, status bit 8 is 1 and bits 7:0 read 0.
- R4: A byte pushed while the queue is full, with no pop in the same cycle, is discarded. The error request pulses in the next cycle, and the queue keeps its content.
- R5: A pop from an empty queue returns 0 on the read data, leaves the count at 0, and pulses the error request in the next cycle.
- R6: Data-ready rises with a stored byte. In queue mode, it falls when a pop removes the last stored byte and stays high while bytes remain.
- R7: Control bit 0 selects queue mode (1) or single-register mode (0). Writing bit 1 as 1 empties the receive queue and clears data-ready. Writing bit 2 as 1 gives a one-cycle transmit flush pulse. Bits 2:1 always read back as 0.
- R8: In single-register mode, a pushed byte replaces the holding register and sets data-ready. The read data shows the holding register, and a pop clears data-ready.
- R9: A break event stores the byte 0x00 and sets error-status bit 3. If a push occurs in the same cycle, the break takes precedence and the pushed byte is dropped.
- R10: Error-status bits 0, 1 and 2 (overrun, parity, frame) are set from the line error inputs and stay set. A read strobe shows the current value and clears it on the following edge; events arriving in the same cycle as the read survive the clear.
- R11: Each successfully stored byte pulses the receive request in the cycle after the push.
- R12: A push and a pop in the same cycle on a non-empty queue leave the count, and the full flag, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Byte offered by the deserialiser |
| push_data | input | DW | Offered byte |
| brk_event | input | 1 | Line break seen (stores 0x00) |
| line_err | input | 3 | Line error flags: 0 overrun, 1 parity, 2 frame |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | Control word: 0 queue mode, 1 receive flush, 2 transmit flush |
| ctl_q | output | 3 | Control readback (flush bits read 0) |
| pop_rd | input | 1 | Read strobe on the data register |
| rd_data | output | DW | Byte returned by the read |
| stat_word | output | 9 | Bits 7:0 count, bit 8 full |
| rdy | output | 1 | Data-ready |
| err_rd | input | 1 | Read strobe on the error-status word |
| err_stat | output | 4 | Sticky error status: 0 overrun, 1 parity, 2 frame, 3 break |
| rx_irq | output | 1 | Receive request pulse |
| err_irq | output | 1 | Error request pulse |
| tx_flush | output | 1 | One-cycle transmit flush pulse |

## Verification
A pointer or level error shows up in the status word in the cycle after the offending edge. When such an error corrupts order, it shows up at the next pop, as a byte that does not match the scoreboard. A data-ready flop that fails to track the level is seen at the first pop that drains the queue. A sticky bit that fails to clear, or one that drops an event arriving with the read, differs from the expected value one edge after the read strobe. The full-flag encoding is checked at the exact DEPTH boundary, both when a push meets it and when a push and a pop arrive together.

// File: rtl/uart_rx_stash_pkg.sv
package uart_rx_stash_pkg;
   localparam int CTL_W     = 3;
   localparam int CTL_EN    = 0;
   localparam int CTL_RXCLR = 1;
   localparam int CTL_TXCLR = 2;

   localparam int ERR_W   = 4;
   localparam int ERR_OVR = 0;
   localparam int ERR_PAR = 1;
   localparam int ERR_FRM = 2;
   localparam int ERR_BRK = 3;

   localparam int CNT_FIELD_W = 8;
   localparam int STAT_W      = CNT_FIELD_W + 1;
endpackage

// File: rtl/uart_rx_stash_fifo.sv
module uart_rx_stash_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] head,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);
   logic [DW-1:0] mem [DEPTH];
   logic [LW-1:0] wp, rp;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wp[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else if (clr) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (wr_en) wp <= wp + LW'(1);
         if (rd_en) rp <= rp + LW'(1);
      end
   end

   assign level = wp - rp;
   assign full  = (level == LW'(DEPTH));
   assign empty = (level == '0);
   assign head  = mem[rp[AW-1:0]];
endmodule

// File: rtl/uart_rx_stash_hold.sv
module uart_rx_stash_hold #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= din;
   end
endmodule

// File: rtl/uart_rx_stash_errs.sv
module uart_rx_stash_errs #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic         rd_clr,
   output logic [W-1:0] q
);
   logic [W-1:0] keep;

   assign keep = rd_clr ? '0 : q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= keep | set;
   end
endmodule

// File: rtl/uart_rx_stash.sv
module uart_rx_stash
   import uart_rx_stash_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int DW    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_valid,
   input  logic [DW-1:0]     push_data,
   input  logic              brk_event,
   input  logic [2:0]        line_err,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   output logic [CTL_W-1:0]  ctl_q,
   input  logic              pop_rd,
   output logic [DW-1:0]     rd_data,
   output logic [STAT_W-1:0] stat_word,
   output logic              rdy,
   input  logic              err_rd,
   output logic [ERR_W-1:0]  err_stat,
   output logic              rx_irq,
   output logic              err_irq,
   output logic              tx_flush
);
   localparam int AW = $clog2(DEPTH);
   localparam int LW = AW + 1;

   generate
      if (DEPTH < 2 || DEPTH > 256)
         $error("uart_rx_stash: DEPTH must lie in 2..256");
      if ((DEPTH & (DEPTH - 1)) != 0)
         $error("uart_rx_stash: DEPTH must be a power of two");
      if (DW < 1)
         $error("uart_rx_stash: DW must be positive");
   endgenerate

   logic          en_q;
   logic          rdy_q, rx_irq_q, err_irq_q, tx_flush_q;
   logic          rx_clr;
   logic          in_valid;
   logic [DW-1:0] in_byte;
   logic          pop_ok, pop_under;
   logic          store_f, store_h, drop;
   logic [DW-1:0] head, hold_q;
   logic [LW-1:0] level;
   logic          full, empty;
   logic [ERR_W-1:0] err_set;

   assign rx_clr   = ctl_wr & ctl_wdata[CTL_RXCLR];
   assign in_valid = push_valid | brk_event;
   assign in_byte  = brk_event ? '0 : push_data;

   assign pop_ok    = en_q & pop_rd & ~empty & ~rx_clr;
   assign pop_under = en_q & pop_rd & empty & ~rx_clr;
   assign store_f   = en_q & in_valid & ~rx_clr & (~full | pop_ok);
   assign store_h   = ~en_q & in_valid & ~rx_clr;
   assign drop      = ~rx_clr & ((en_q & in_valid & full & ~pop_ok)
                                 | (push_valid & brk_event));

   uart_rx_stash_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (rx_clr),
      .wr_en  (store_f),
      .wr_data(in_byte),
      .rd_en  (pop_ok),
      .head   (head),
      .level  (level),
      .full   (full),
      .empty  (empty)
   );

   uart_rx_stash_hold #(.DW(DW)) u_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .load (store_h),
      .din  (in_byte),
      .q    (hold_q)
   );

   assign err_set[ERR_OVR] = line_err[0];
   assign err_set[ERR_PAR] = line_err[1];
   assign err_set[ERR_FRM] = line_err[2];
   assign err_set[ERR_BRK] = brk_event;

   uart_rx_stash_errs #(.W(ERR_W)) u_errs (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (err_set),
      .rd_clr(err_rd),
      .q     (err_stat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= 1'b0;
         rdy_q      <= 1'b0;
         rx_irq_q   <= 1'b0;
         err_irq_q  <= 1'b0;
         tx_flush_q <= 1'b0;
      end else begin
         if (ctl_wr) en_q <= ctl_wdata[CTL_EN];
         tx_flush_q <= ctl_wr & ctl_wdata[CTL_TXCLR];
         rx_irq_q   <= store_f | store_h;
         err_irq_q  <= drop | pop_under | brk_event | (|line_err);
         if (rx_clr)
            rdy_q <= 1'b0;
         else if (store_f | store_h)
            rdy_q <= 1'b1;
         else if (pop_ok && level == LW'(1))
            rdy_q <= 1'b0;
         else if (!en_q && pop_rd)
            rdy_q <= 1'b0;
      end
   end

   assign ctl_q     = {2'b00, en_q};
   assign rd_data   = en_q ? (empty ? '0 : head) : hold_q;
   assign stat_word = full ? {1'b1, {CNT_FIELD_W{1'b0}}}
                           : {1'b0, CNT_FIELD_W'(level)};
   assign rdy       = rdy_q;
   assign rx_irq    = rx_irq_q;
   assign err_irq   = err_irq_q;
   assign tx_flush  = tx_flush_q;
endmodule

// File: rtl/uart_rx_stash_chk.sv
module uart_rx_stash_chk #(
   parameter int DEPTH = 16,
   parameter int DW    = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          push_valid,
   input logic          brk_event,
   input logic [2:0]    line_err,
   input logic          ctl_wr,
   input logic [2:0]    ctl_wdata,
   input logic [2:0]    ctl_q,
   input logic          pop_rd,
   input logic [8:0]    stat_word,
   input logic          rdy,
   input logic          err_rd,
   input logic [3:0]    err_stat,
   input logic          rx_irq,
   input logic          err_irq
);
   logic fifo_on, is_full;
   logic [7:0] cnt;
   assign fifo_on = ctl_q[0];
   assign is_full = stat_word[8];
   assign cnt     = stat_word[7:0];

   // R4
   a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_on && is_full && push_valid && !pop_rd && !brk_event && !ctl_wr
      |=> is_full && err_irq);

   // R5
   a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_on && !is_full && cnt == 8'd0 && pop_rd && !ctl_wr
      |=> err_irq);

   // R6
   a_r6_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_on && !is_full && cnt == 8'd1 && pop_rd && !push_valid
      && !brk_event && !ctl_wr |=> !rdy);

   // R7
   a_r7_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && ctl_wdata[1] |=> stat_word == 9'd0 && !rdy);

   // R10
   a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      err_rd && !brk_event && line_err == 3'b000 |=> err_stat == 4'd0);

   // R11
   a_r11_store_req: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_on && push_valid && !is_full && !brk_event && !ctl_wr |=> rx_irq);

   // R12
   a_r12_balance: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_on && push_valid && pop_rd && !brk_event && !ctl_wr
      && (is_full || cnt != 8'd0) |=> $stable(stat_word));
endmodule

bind uart_rx_stash uart_rx_stash_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .push_valid(push_valid),
   .brk_event (brk_event),
   .line_err  (line_err),
   .ctl_wr    (ctl_wr),
   .ctl_wdata (ctl_wdata),
   .ctl_q     (ctl_q),
   .pop_rd    (pop_rd),
   .stat_word (stat_word),
   .rdy       (rdy),
   .err_rd    (err_rd),
   .err_stat  (err_stat),
   .rx_irq    (rx_irq),
   .err_irq   (err_irq)
);

// File: tb/uart_rx_stash_bench.sv
module uart_rx_stash_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic push_valid = 1'b0;
   logic [DW-1:0] push_data = '0;
   logic brk_event = 1'b0;
   logic [2:0] line_err = '0;
   logic ctl_wr = 1'b0;
   logic [2:0] ctl_wdata = '0;
   logic [2:0] ctl_q;
   logic pop_rd = 1'b0;
   logic [DW-1:0] rd_data;
   logic [8:0] stat_word;
   logic rdy;
   logic err_rd = 1'b0;
   logic [3:0] err_stat;
   logic rx_irq, err_irq, tx_flush;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [DW-1:0] model_q[$];
   logic [DW-1:0] model_hold = '0;
   bit model_fifo = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_rx_stash #(.DEPTH(DEPTH), .DW(DW)) u_uart_rx_stash (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
      .brk_event(brk_event), .line_err(line_err), .ctl_wr(ctl_wr),
      .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .pop_rd(pop_rd), .rd_data(rd_data),
      .stat_word(stat_word), .rdy(rdy), .err_rd(err_rd), .err_stat(err_stat),
      .rx_irq(rx_irq), .err_irq(err_irq), .tx_flush(tx_flush)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: compares read data against the scoreboard before each pop edge
   always @(negedge clk) begin
      if (rst_n && pop_rd && !done) begin
         if (model_fifo) begin
            if (model_q.size() > 0) check("R2 pop order", rd_data, model_q.pop_front());
            else                    check("R5 empty pop data", rd_data, 0);
         end else begin
            check("R8 holding data", rd_data, model_hold);
         end
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic push_b(logic [DW-1:0] b, bit with_pop);
      push_valid = 1'b1;
      push_data  = b;
      pop_rd     = with_pop;
      cyc();
      push_valid = 1'b0;
      pop_rd     = 1'b0;
      if (model_fifo) begin
         if (model_q.size() < DEPTH) model_q.push_back(b);
      end else begin
         model_hold = b;
      end
   endtask

   task automatic pop_b();
      pop_rd = 1'b1;
      cyc();
      pop_rd = 1'b0;
   endtask

   task automatic ctl(logic [2:0] v);
      ctl_wr    = 1'b1;
      ctl_wdata = v;
      cyc();
      ctl_wr    = 1'b0;
      ctl_wdata = '0;
      model_fifo = v[0];
      if (v[1]) model_q.delete();
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1 stat", stat_word, 0);
      check("R1 rdy", rdy, 0);
      check("R1 err_stat", err_stat, 0);
      check("R1 ctl_q", ctl_q, 0);
      check("R1 pulses", {rx_irq, err_irq, tx_flush}, 0);
      rst_n = 1'b1;
      cyc();

      // R7 queue mode on
      ctl(3'b001);
      check("R7 ctl readback", ctl_q, 3'b001);

      // R2/R11/R6 basic pushes
      push_b(8'hA5, 0);
      check("R11 rx req", rx_irq, 1);
      check("R6 rdy set", rdy, 1);
      push_b(8'h3C, 0);
      push_b(8'h7E, 0);
      check("R2 count", stat_word, 3);
      pop_b();
      check("R6 rdy kept", rdy, 1);
      pop_b();
      pop_b();
      check("R6 rdy cleared", rdy, 0);
      check("R2 count empty", stat_word, 0);

      // R5 empty pop
      pop_b();
      check("R5 err req", err_irq, 1);
      check("R5 count", stat_word, 0);

      // R3/R4/R12 full boundary
      for (int i = 0; i < DEPTH; i++) push_b(8'(i * 7 + 1), 0);
      check("R3 full word", stat_word, 9'h100);
      push_b(8'hEE, 0);
      check("R4 err req", err_irq, 1);
      check("R4 no rx req", rx_irq, 0);
      check("R4 still full", stat_word, 9'h100);
      push_b(8'h99, 1);
      check("R12 full balanced", stat_word, 9'h100);
      for (int i = 0; i < DEPTH; i++) pop_b();
      check("R2 drained", stat_word, 0);
      check("R6 drained rdy", rdy, 0);

      // R7 receive flush and transmit flush
      push_b(8'h10, 0);
      push_b(8'h20, 0);
      ctl(3'b011);
      check("R7 rx flush count", stat_word, 0);
      check("R7 rx flush rdy", rdy, 0);
      check("R7 self clear", ctl_q, 3'b001);
      ctl(3'b101);
      check("R7 tx flush pulse", tx_flush, 1);
      check("R7 self clear tx", ctl_q, 3'b001);
      cyc();
      check("R7 tx flush single", tx_flush, 0);

      // R12 partial balance
      push_b(8'h41, 0);
      push_b(8'h42, 0);
      push_b(8'h43, 1);
      check("R12 count kept", stat_word, 2);

      // R9 break
      brk_event = 1'b1;
      cyc();
      brk_event = 1'b0;
      model_q.push_back(8'h00);
      check("R9 count", stat_word, 3);
      check("R9 err bit", err_stat, 4'b1000);
      check("R9 err req", err_irq, 1);
      pop_b();
      pop_b();
      pop_b();

      // R10 sticky errors and clear on read
      line_err = 3'b101;
      cyc();
      line_err = 3'b000;
      check("R10 sticky", err_stat, 4'b1101);
      cyc();
      check("R10 held", err_stat, 4'b1101);
      err_rd = 1'b1;
      line_err = 3'b010;
      #1;
      check("R10 read value", err_stat, 4'b1101);
      cyc();
      err_rd = 1'b0;
      line_err = 3'b000;
      check("R10 new event survives", err_stat, 4'b0010);
      err_rd = 1'b1;
      cyc();
      err_rd = 1'b0;
      check("R10 cleared", err_stat, 0);

      // R8 single-register mode
      ctl(3'b010);
      ctl(3'b000);
      check("R8 mode", ctl_q, 0);
      push_b(8'h11, 0);
      check("R8 rdy", rdy, 1);
      push_b(8'h22, 0);
      check("R8 overwrite", rd_data, 8'h22);
      check("R8 no count", stat_word, 0);
      pop_b();
      check("R8 rdy cleared", rdy, 0);

      cyc();
      finish_run();
   end
endmodule